// File: doc/BRIEF.md
# Strobe-Steered Hold-Until-Done Dispatcher

This block turns a single-cycle request strobe into a held line on one of several output channels. A select word arrives with the strobe and picks the channel. That channel's line rises on the clock edge that samples the strobe. It stays high until the completion input that belongs to the same channel is seen high, and then it falls. Completion inputs of other channels never release it.

Each channel holds at most one outstanding request. A strobe aimed at a channel that is already held does not start a second interval; it only marks a sticky per-channel overrun flag. A select value that names no channel is dropped and marks a sticky range-error flag. The reset input may rise at any moment and clears everything at once. Its fall passes through a two-flop synchronizer, so internal state leaves reset in step with the clock.

Top module: `chan_dispatch`

## Requirements
- R1: While the synchronized reset is active, every busy line, every overrun flag and the range-error flag read 0. Reset is the only event that clears the sticky flags.
- R2: A strobe whose select value s is below N_CH, sampled while channel s is idle, sets busy_out[s] on that same edge. Bit s of busy_out corresponds to select value s.
- R3: A held channel stays high on every edge where its own done_in bit is low, whatever the strobe, the select word or the other done bits do.
- R4: A held channel whose done_in bit is high at an edge goes low on that edge. A done that is already high on the first edge after the rise therefore gives a one-cycle pulse.
- R5: A done_in pulse on an idle channel has no effect. The channel stays idle unless a strobe selects it on that edge, and in that case it rises.
- R6: A strobe that selects a channel already held leaves that channel's interval unchanged (no second rise) and sets overrun_flag for that channel, which then stays set.
- R7: A strobe with a select value of N_CH or more raises no busy line and sets bad_sel_flag, which then stays set.
- R8: Raising rst_in clears all outputs at once, without waiting for a clock. After rst_in falls, strobes sampled on the first two clock edges are ignored, and the strobe on the third edge is the first one acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_in | input | 1 | Active-high reset; takes effect at once, released through a synchronizer |
| req_strobe | input | 1 | One-cycle request pulse |
| req_sel | input | SEL_W | Channel select that comes with the strobe |
| done_in | input | N_CH | Per-channel completion inputs |
| busy_out | output | N_CH | Per-channel held output lines |
| overrun_flag | output | N_CH | Sticky flag: a request arrived while the channel was held |
| bad_sel_flag | output | 1 | Sticky flag: a request named a channel that does not exist |

## Verification
The bench builds the block with six channels and a 3-bit select. With these values the select codes 6 and 7 exist but name no channel, so the range-error path can be reached directly. Six channels are enough to hold five at once and release them out of order, while done pulses arrive on idle neighbours. Mid-run reset and the two-edge release latency are exercised with channels held and flags set, so the clearing is visible at the ports.

// File: rtl/chan_dispatch_pkg.sv
package chan_dispatch_pkg;

  // State of one hold-until-done channel.
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_e;

  // Number of flops in the reset release chain.
  localparam int RST_STAGES = 2;

endpackage

// File: rtl/dsp_reset_sync.sv
module dsp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async,
  output logic rst_sync
);

  logic [STAGES-1:0] stg;

  // Assert immediately, release after STAGES edges.
  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      stg <= '1;
    end else begin
      stg <= {stg[STAGES-2:0], 1'b0};
    end
  end

  assign rst_sync = stg[STAGES-1];

endmodule

// File: rtl/dsp_sel_decode.sv
module dsp_sel_decode #(
  parameter int N_CH  = 6,
  parameter int SEL_W = 3
) (
  input  logic             strobe,
  input  logic [SEL_W-1:0] sel,
  output logic [N_CH-1:0]  hit,
  output logic             bad
);

  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(N_CH);

  logic in_range;

  assign in_range = ({1'b0, sel} < SEL_LIMIT);
  assign bad      = strobe & ~in_range;

  for (genvar gi = 0; gi < N_CH; gi++) begin : g_hit
    assign hit[gi] = strobe & in_range & (sel == SEL_W'(gi));
  end

endmodule

// File: rtl/dsp_hold_slot.sv
module dsp_hold_slot
  import chan_dispatch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic done,
  output logic busy,
  output logic overrun
);

  slot_state_e state;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= SLOT_IDLE;
      overrun <= 1'b0;
    end else begin
      case (state)
        SLOT_IDLE: begin
          if (hit) state <= SLOT_HELD;
        end
        SLOT_HELD: begin
          if (done) state <= SLOT_IDLE;
          if (hit) overrun <= 1'b1;
        end
        default: state <= SLOT_IDLE;
      endcase
    end
  end

  assign busy = (state == SLOT_HELD);

endmodule

// File: rtl/chan_dispatch.sv
module chan_dispatch
  import chan_dispatch_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic             req_strobe,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [N_CH-1:0]  done_in,
  output logic [N_CH-1:0]  busy_out,
  output logic [N_CH-1:0]  overrun_flag,
  output logic             bad_sel_flag
);

  logic            rst_s;
  logic [N_CH-1:0] hit;
  logic            bad_hit;

  dsp_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk       (clk),
    .rst_async (rst_in),
    .rst_sync  (rst_s)
  );

  dsp_sel_decode #(.N_CH(N_CH), .SEL_W(SEL_W)) u_dec (
    .strobe (req_strobe),
    .sel    (req_sel),
    .hit    (hit),
    .bad    (bad_hit)
  );

  for (genvar gc = 0; gc < N_CH; gc++) begin : g_slot
    dsp_hold_slot u_slot (
      .clk     (clk),
      .rst     (rst_s),
      .hit     (hit[gc]),
      .done    (done_in[gc]),
      .busy    (busy_out[gc]),
      .overrun (overrun_flag[gc])
    );
  end

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) begin
      bad_sel_flag <= 1'b0;
    end else if (bad_hit) begin
      bad_sel_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/chan_dispatch_chk.sv
module chan_dispatch_chk #(
  parameter int N_CH  = 6,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_in,
  input logic             rst_s,
  input logic             req_strobe,
  input logic [SEL_W-1:0] req_sel,
  input logic [N_CH-1:0]  done_in,
  input logic [N_CH-1:0]  busy_out,
  input logic [N_CH-1:0]  overrun_flag,
  input logic             bad_sel_flag
);

  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(N_CH);

  logic sel_bad;
  assign sel_bad = req_strobe && ({1'b0, req_sel} >= SEL_LIMIT);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst_s |-> (busy_out == '0 && overrun_flag == '0 && !bad_sel_flag));

  p_release_latency_r8: assert property (@(posedge clk)
    rst_in |=> rst_s ##1 rst_s);

  p_bad_sel_r7: assert property (@(posedge clk) disable iff (rst_s)
    sel_bad |=> (bad_sel_flag && ((busy_out & ~$past(busy_out)) == '0)));

  p_bad_sticky_r7: assert property (@(posedge clk) disable iff (rst_s)
    bad_sel_flag |=> bad_sel_flag);

  for (genvar gk = 0; gk < N_CH; gk++) begin : g_ch
    logic sel_me;
    assign sel_me = req_strobe && (req_sel == SEL_W'(gk));

    p_raise_r2: assert property (@(posedge clk) disable iff (rst_s)
      (sel_me && !busy_out[gk]) |=> busy_out[gk]);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst_s)
      (busy_out[gk] && !done_in[gk]) |=> busy_out[gk]);

    p_release_r4: assert property (@(posedge clk) disable iff (rst_s)
      (busy_out[gk] && done_in[gk]) |=> !busy_out[gk]);

    p_idle_stays_r5: assert property (@(posedge clk) disable iff (rst_s)
      (!busy_out[gk] && !sel_me) |=> !busy_out[gk]);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst_s)
      (sel_me && busy_out[gk]) |=> overrun_flag[gk]);

    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst_s)
      overrun_flag[gk] |=> overrun_flag[gk]);
  end

endmodule

bind chan_dispatch chan_dispatch_chk #(.N_CH(N_CH), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_in       (rst_in),
  .rst_s        (rst_s),
  .req_strobe   (req_strobe),
  .req_sel      (req_sel),
  .done_in      (done_in),
  .busy_out     (busy_out),
  .overrun_flag (overrun_flag),
  .bad_sel_flag (bad_sel_flag)
);

// File: tb/sim_chan_dispatch.sv
module sim_chan_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 6;
  localparam int SEL_W = 3;

  logic             clk;
  logic             rst_in;
  logic             req_strobe;
  logic [SEL_W-1:0] req_sel;
  logic [N_CH-1:0]  done_in;
  logic [N_CH-1:0]  busy_out;
  logic [N_CH-1:0]  overrun_flag;
  logic             bad_sel_flag;

  chan_dispatch #(.N_CH(N_CH), .SEL_W(SEL_W)) u0 (
    .clk          (clk),
    .rst_in       (rst_in),
    .req_strobe   (req_strobe),
    .req_sel      (req_sel),
    .done_in      (done_in),
    .busy_out     (busy_out),
    .overrun_flag (overrun_flag),
    .bad_sel_flag (bad_sel_flag)
  );

  typedef struct {
    logic [N_CH-1:0] busy;
    logic [N_CH-1:0] ovr;
    logic            bad;
    string           tag;
  } exp_t;

  exp_t q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Reference state, built from the requirements.
  logic [N_CH-1:0] m_busy = '0;
  logic [N_CH-1:0] m_ovr  = '0;
  logic            m_bad  = 1'b0;
  int              m_hold = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input logic s, input logic [SEL_W-1:0] sel,
                      input logic [N_CH-1:0] dn, input string tag);
    exp_t e;
    req_strobe = s;
    req_sel    = sel;
    done_in    = dn;
    @(posedge clk);
    if (m_hold > 0) begin
      m_hold--;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        logic h;
        h = s && (int'(sel) == i);
        if (m_busy[i]) begin
          if (h) m_ovr[i] = 1'b1;
          m_busy[i] = !dn[i];
        end else begin
          m_busy[i] = h;
        end
      end
      if (s && int'(sel) >= N_CH) m_bad = 1'b1;
    end
    e.busy = m_busy;
    e.ovr  = m_ovr;
    e.bad  = m_bad;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    req_strobe = 1'b0;
    done_in    = '0;
  endtask

  // Monitor: compare outputs against the queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " busy"},    8'(busy_out),     8'(e.busy));
        chk({e.tag, " overrun"}, 8'(overrun_flag), 8'(e.ovr));
        chk({e.tag, " badsel"},  8'(bad_sel_flag), 8'(e.bad));
      end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired before R1..R8 sequence completed");
      report();
      $finish;
    end
  end

  initial begin
    rst_in     = 1'b1;
    req_strobe = 1'b0;
    req_sel    = '0;
    done_in    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs clear during reset
    chk("R1 reset busy",    8'(busy_out),     8'h00);
    chk("R1 reset overrun", 8'(overrun_flag), 8'h00);
    chk("R1 reset badsel",  8'(bad_sel_flag), 8'h00);

    rst_in = 1'b0;
    m_hold = 2;
    // R8: first two edges after release ignore strobes
    step(1'b1, 3'd0, '0, "R8 edge1");
    step(1'b1, 3'd1, '0, "R8 edge2");
    step(1'b1, 3'd2, '0, "R2 raise ch2");
    step(1'b0, 3'd0, '0, "R3 hold ch2");
    step(1'b0, 3'd0, 6'b000011, "R5 done idle ch0/1");
    step(1'b0, 3'd0, 6'b010000, "R3 foreign done ch4");
    step(1'b0, 3'd0, 6'b000100, "R4 release ch2");

    // R4: one-cycle minimum width
    step(1'b1, 3'd3, '0, "R2 raise ch3");
    step(1'b0, 3'd0, 6'b001000, "R4 one-cycle ch3");

    // R6: request to a held channel
    step(1'b1, 3'd5, '0, "R2 raise ch5");
    step(1'b1, 3'd5, '0, "R6 overrun ch5");
    step(1'b0, 3'd0, '0, "R6 still held ch5");
    step(1'b1, 3'd5, 6'b100000, "R6 req+done ch5");
    step(1'b0, 3'd0, '0, "R6 single interval ch5");

    // R5: done and request together on an idle channel
    step(1'b1, 3'd1, 6'b000010, "R5 req+done idle ch1");
    step(1'b0, 3'd0, 6'b000010, "R4 release ch1");

    // R7: out-of-range selects
    step(1'b1, 3'd6, '0, "R7 sel6");
    step(1'b1, 3'd7, '0, "R7 sel7");
    step(1'b0, 3'd0, '0, "R7 sticky");

    // Several held at once, released out of order
    for (int c = 0; c < 5; c++) step(1'b1, SEL_W'(c), '0, "R2 fill");
    step(1'b0, 3'd0, 6'b010001, "R3 partial release");
    step(1'b0, 3'd0, 6'b100000, "R5 done idle ch5");
    step(1'b0, 3'd0, 6'b000110, "R4 release ch1/2");

    // R8: reset acts without a clock, mid cycle
    #1 rst_in = 1'b1;
    #1;
    chk("R8 async busy",    8'(busy_out),     8'h00);
    chk("R8 async overrun", 8'(overrun_flag), 8'h00);
    chk("R8 async badsel",  8'(bad_sel_flag), 8'h00);
    m_busy = '0;
    m_ovr  = '0;
    m_bad  = 1'b0;
    repeat (2) @(negedge clk);
    rst_in = 1'b0;
    m_hold = 2;
    step(1'b1, 3'd0, '0, "R8 edge1 again");
    step(1'b1, 3'd0, '0, "R8 edge2 again");
    step(1'b1, 3'd0, '0, "R1 flags cleared, ch0 raised");
    step(1'b0, 3'd0, 6'b000001, "R4 release ch0");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    report();
    $finish;
  end

endmodule